// File: doc/BRIEF.md
# Wishbone Register Bank with RAM Window

This block is a Wishbone classic slave that holds a small register bank for the logic around it. A bus master reaches a read-write control word, a read-only status word, a constant identification word, a write-only command field and an internal RAM window. The command field also raises a one-cycle strobe toward the user side. The slave turns CYC, STB and WE into separate read and write requests. Read data passes through a register. Every access gets exactly one acknowledge, and that includes an access to an address that decodes to nothing.

Back-pressure is carried by STALL. It is high while an access is enabled and its acknowledge has not yet come, and it drops in the cycle the acknowledge is returned. The master must hold address, data and WE steady until it sees the acknowledge. A register access is acknowledged one cycle after the request is sampled. A RAM write takes one extra cycle, because the write enable is registered first and the acknowledge follows it.

Top module: `regbank_wb`

## Requirements
- R1: An access is enabled when `cyc_i` and `stb_i` are both high. It is a read when `we_i` is low and a write when `we_i` is high. `ack_o` is never high unless an access was enabled at the preceding clock edge.
- R2: `stall_o` is high exactly when an access is enabled and `ack_o` is low.
- R3: A write to the control word (word 0) updates `ctrl_o` and is acknowledged for exactly one cycle, one cycle after the request is sampled. If the request is still held in the acknowledge cycle, it is not accepted again in that cycle.
- R4: A read is acknowledged one cycle after the request is sampled. While `ack_o` is high, `dat_o` holds the value that was selected at that edge.
- R5: A write to an unmapped word is acknowledged and changes nothing. A read from an unmapped word is acknowledged and returns zero.
- R6: RAM words RAM_BASE_W to RAM_BASE_W+2^RAM_AW-1 (16..31 by default) read back what was written. A RAM write is acknowledged two cycles after the request is sampled. A RAM read is acknowledged after one cycle.
- R7: A write to the command word (word 3) loads its low CMD_W bits into `cmd_o`. It raises `cmd_pulse_o` for exactly one cycle, in the same cycle as the acknowledge. A read of word 3 returns zero.
- R8: After reset, `ctrl_o` equals CTRL_PRESET, `cmd_o` is zero, and `cmd_pulse_o`, `ack_o` and `stall_o` are low.
- R9: Word 1 reads `status_i` as sampled at the acknowledge edge. Word 2 reads ID_VALUE. Writes to either word are acknowledged and have no effect.
- R10: `adr_i` carries the word address, which is byte address bits [ADDR_W-1:2]. Data is 32 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Strobe for this slave |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W-2 | Word address (byte address bits [ADDR_W-1:2]) |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Registered read data |
| ack_o | output | 1 | Access acknowledge |
| stall_o | output | 1 | Access waiting for its acknowledge |
| status_i | input | 32 | Value returned by the status word |
| ctrl_o | output | 32 | Control word contents |
| cmd_o | output | CMD_W | Last value written to the command field |
| cmd_pulse_o | output | 1 | One-cycle strobe on a command write |

## Verification
A command write produces both the user-side strobe and the bus acknowledge in the same cycle. The bench provokes this with single command writes, and with a command write whose strobe is held for several cycles, so that acknowledges and strobes alternate. Both outputs are then judged in the same clock against a behavioural model. Stall and acknowledge also meet at one edge: stall must be high right after a request is driven and must drop in the very cycle the acknowledge appears. The bench checks this on every clock for both the one-cycle register path and the two-cycle RAM-write path.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW = 32;

  // fixed word offsets of the register bank
  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_ID   = 2;
  localparam int OFF_CMD  = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_ID,
    SEL_CMD,
    SEL_RAM
  } sel_e;
endpackage

// File: rtl/regbank_dec.sv
module regbank_dec
  import regbank_pkg::*;
#(
  parameter int WA         = 6,
  parameter int RAM_AW     = 4,
  parameter int RAM_BASE_W = 16
) (
  input  logic [WA-1:0]     wadr,
  output sel_e              sel,
  output logic [RAM_AW-1:0] ram_idx
);
  localparam logic [WA-1:0] RAM_TAG = WA'(RAM_BASE_W >> RAM_AW);

  assign ram_idx = wadr[RAM_AW-1:0];

  always_comb begin
    sel = SEL_NONE;
    if      (wadr == WA'(OFF_CTRL))      sel = SEL_CTRL;
    else if (wadr == WA'(OFF_STAT))      sel = SEL_STAT;
    else if (wadr == WA'(OFF_ID))        sel = SEL_ID;
    else if (wadr == WA'(OFF_CMD))       sel = SEL_CMD;
    else if ((wadr >> RAM_AW) == RAM_TAG) sel = SEL_RAM;
  end
endmodule

// File: rtl/regbank_ram.sv
module regbank_ram #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/regbank_wr.sv
module regbank_wr
  import regbank_pkg::*;
#(
  parameter int          CMD_W       = 8,
  parameter logic [31:0] CTRL_PRESET = 32'h0000_00A5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req,
  input  sel_e             sel,
  input  logic [DW-1:0]    wdat,
  output logic             wr_ack,
  output logic [DW-1:0]    ctrl_q,
  output logic [CMD_W-1:0] cmd_q,
  output logic             cmd_pulse,
  output logic             ram_we
);
  logic ram_pend;

  assign ram_we = ram_pend;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_ack    <= 1'b0;
      ram_pend  <= 1'b0;
      cmd_pulse <= 1'b0;
      ctrl_q    <= CTRL_PRESET;
      cmd_q     <= '0;
    end else begin
      cmd_pulse <= 1'b0;
      if (ram_pend) begin
        // memory is written at this edge; acknowledge follows
        ram_pend <= 1'b0;
        wr_ack   <= 1'b1;
      end else if (wr_req && !wr_ack) begin
        unique case (sel)
          SEL_CTRL: begin
            ctrl_q <= wdat;
            wr_ack <= 1'b1;
          end
          SEL_CMD: begin
            cmd_q     <= wdat[CMD_W-1:0];
            cmd_pulse <= 1'b1;
            wr_ack    <= 1'b1;
          end
          SEL_RAM: ram_pend <= 1'b1;
          default: wr_ack <= 1'b1;
        endcase
      end else begin
        wr_ack <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regbank_rd.sv
module regbank_rd
  import regbank_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h5EB0_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req,
  input  sel_e          sel,
  input  logic [DW-1:0] ctrl_q,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] ram_rdata,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mux;

  always_comb begin
    unique case (sel)
      SEL_CTRL: mux = ctrl_q;
      SEL_STAT: mux = status_i;
      SEL_ID:   mux = ID_VALUE;
      SEL_RAM:  mux = ram_rdata;
      default:  mux = '0;  // command field and unmapped words
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else if (rd_req && !rd_ack) begin
      rd_ack  <= 1'b1;
      rd_data <= mux;
    end else begin
      rd_ack <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_wb.sv
module regbank_wb
  import regbank_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          RAM_AW      = 4,
  parameter int          RAM_BASE_W  = 16,
  parameter int          CMD_W       = 8,
  parameter logic [31:0] CTRL_PRESET = 32'h0000_00A5,
  parameter logic [31:0] ID_VALUE    = 32'h5EB0_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:2] adr_i,
  input  logic [DW-1:0]     dat_i,
  output logic [DW-1:0]     dat_o,
  output logic              ack_o,
  output logic              stall_o,
  input  logic [DW-1:0]     status_i,
  output logic [DW-1:0]     ctrl_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmd_pulse_o
);
  localparam int WA = ADDR_W - 2;

  logic              en, rd_req, wr_req, rd_ack, wr_ack, ram_we;
  sel_e              sel;
  logic [RAM_AW-1:0] ram_idx;
  logic [DW-1:0]     ram_rdata;

  assign en     = cyc_i & stb_i;
  assign rd_req = en & ~we_i;
  assign wr_req = en & we_i;

  regbank_dec #(.WA(WA), .RAM_AW(RAM_AW), .RAM_BASE_W(RAM_BASE_W)) u_dec (
    .wadr(adr_i), .sel(sel), .ram_idx(ram_idx)
  );

  regbank_ram #(.DW(DW), .AW(RAM_AW)) u_ram (
    .clk_i(clk_i), .we(ram_we), .idx(ram_idx), .wdata(dat_i), .rdata(ram_rdata)
  );

  regbank_wr #(.CMD_W(CMD_W), .CTRL_PRESET(CTRL_PRESET)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_req(wr_req), .sel(sel), .wdat(dat_i),
    .wr_ack(wr_ack), .ctrl_q(ctrl_o), .cmd_q(cmd_o), .cmd_pulse(cmd_pulse_o),
    .ram_we(ram_we)
  );

  regbank_rd #(.ID_VALUE(ID_VALUE)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_req(rd_req), .sel(sel), .ctrl_q(ctrl_o),
    .status_i(status_i), .ram_rdata(ram_rdata), .rd_ack(rd_ack), .rd_data(dat_o)
  );

  assign ack_o   = rd_ack | wr_ack;
  assign stall_o = en & ~ack_o;
endmodule

// File: rtl/regbank_wb_chk.sv
module regbank_wb_chk #(
  parameter int ADDR_W     = 8,
  parameter int RAM_AW     = 4,
  parameter int RAM_BASE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_i,
  input logic              stb_i,
  input logic              we_i,
  input logic [ADDR_W-1:2] adr_i,
  input logic              ack_o,
  input logic              stall_o,
  input logic              cmd_pulse_o
);
  localparam int WA = ADDR_W - 2;
  logic in_ram;
  assign in_ram = (adr_i >> RAM_AW) == WA'(RAM_BASE_W >> RAM_AW);

  a_r2_stall_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i && !ack_o) |-> stall_o);
  a_r2_no_stall_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !stall_o);
  a_r1_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(cyc_i && stb_i));
  a_r3_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r7_pulse_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pulse_o |-> (ack_o && $past(we_i)));
  a_r7_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pulse_o |=> !cmd_pulse_o);
  a_r6_ram_write_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && we_i && in_ram) |-> $past(cyc_i && stb_i && we_i, 2));
endmodule

bind regbank_wb regbank_wb_chk #(
  .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .RAM_BASE_W(RAM_BASE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
  .adr_i(adr_i), .ack_o(ack_o), .stall_o(stall_o), .cmd_pulse_o(cmd_pulse_o)
);

// File: tb/regbank_wb_tb.sv
module regbank_wb_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 8;
  localparam int          CMD_W      = 8;
  localparam logic [31:0] PRESET     = 32'h0000_00A5;
  localparam logic [31:0] IDV        = 32'h5EB0_0001;

  logic              clk = 0, rst_n = 0;
  logic              cyc = 0, stb = 0, we = 0;
  logic [ADDR_W-1:2] adr = '0;
  logic [31:0]       dat = '0, status = 32'hCAFE_0001;
  logic [31:0]       dat_o, ctrl_o;
  logic              ack_o, stall_o, cmd_pulse_o;
  logic [CMD_W-1:0]  cmd_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_wb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(dat), .dat_o(dat_o), .ack_o(ack_o), .stall_o(stall_o),
    .status_i(status), .ctrl_o(ctrl_o), .cmd_o(cmd_o), .cmd_pulse_o(cmd_pulse_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_rack = 0, m_wack = 0, m_pend = 0, m_pulse = 0;
  logic [31:0] m_ctrl = PRESET, m_rdat = 0;
  logic [7:0]  m_cmd = 0;
  logic [31:0] m_ram [int];
  int          w;

  function automatic logic [31:0] lookup(input int a);
    if (a == 0) return m_ctrl;
    if (a == 1) return status;
    if (a == 2) return IDV;
    if (a >= 16 && a < 32) return m_ram.exists(a) ? m_ram[a] : 32'h0;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rack = 0; m_wack = 0; m_pend = 0; m_pulse = 0;
      m_ctrl = PRESET; m_cmd = 0;
    end else begin
      w = int'(adr);
      m_pulse = 0;
      if (cyc && stb && !we && !m_rack) begin
        m_rack = 1; m_rdat = lookup(w);
      end else m_rack = 0;
      if (m_pend) begin
        m_ram[w] = dat; m_pend = 0; m_wack = 1;
      end else if (cyc && stb && we && !m_wack) begin
        if (w == 0) begin m_ctrl = dat; m_wack = 1; end
        else if (w == 3) begin m_cmd = dat[7:0]; m_pulse = 1; m_wack = 1; end
        else if (w >= 16 && w < 32) m_pend = 1;
        else m_wack = 1;
      end else m_wack = 0;
    end
  end

  // compare every clock, away from both edges
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #1;
      chk("R1 ack", 32'(ack_o), 32'(m_rack | m_wack));
      chk("R2 stall", 32'(stall_o), 32'(cyc && stb && !(m_rack | m_wack)));
      if (m_rack) chk("R4 read data", dat_o, m_rdat);
      chk("R3 ctrl_o", ctrl_o, m_ctrl);
      chk("R7 cmd_o", 32'(cmd_o), 32'(m_cmd));
      chk("R7 cmd_pulse_o", 32'(cmd_pulse_o), 32'(m_pulse));
    end
  end

  // ---------------- bus tasks ----------------
  logic pulse_at_ack;

  task automatic bus_write(input int a, input logic [31:0] d, output int lat);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a[ADDR_W-3:0]; dat = d; lat = 0;
    #2 chk("R2 stall after request", 32'(stall_o), 32'd1);
    do begin @(negedge clk); lat++; end while (!ack_o && lat < 20);
    pulse_at_ack = cmd_pulse_o;
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d, output int lat);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a[ADDR_W-3:0]; lat = 0;
    do begin @(negedge clk); lat++; end while (!ack_o && lat < 20);
    d = dat_o;
    cyc = 0; stb = 0;
  endtask

  initial begin
    int WD = 100000;
    repeat (WD) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 ack", 32'(ack_o), 0);
    chk("R8 stall", 32'(stall_o), 0);
    chk("R8 ctrl preset", ctrl_o, PRESET);
    chk("R8 cmd", 32'(cmd_o), 0);
    chk("R8 pulse", 32'(cmd_pulse_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R10 map / R8 preset readback, R4 latency
    bus_read(0, rd, lat);
    chk("R10 ctrl word 0 read", rd, PRESET);
    chk("R4 read latency", lat, 1);

    // R3 control write
    bus_write(0, 32'h1234_5678, lat);
    chk("R3 write latency", lat, 1);
    bus_read(0, rd, lat);
    chk("R3 ctrl readback", rd, 32'h1234_5678);

    // R9 status and id, writes ignored
    bus_read(1, rd, lat);
    chk("R9 status read", rd, 32'hCAFE_0001);
    status = 32'h0BAD_F00D;
    bus_write(1, 32'hFFFF_FFFF, lat);
    bus_read(1, rd, lat);
    chk("R9 status after write", rd, 32'h0BAD_F00D);
    bus_write(2, 32'h0, lat);
    bus_read(2, rd, lat);
    chk("R9 id read", rd, IDV);
    chk("R9 ctrl untouched", ctrl_o, 32'h1234_5678);

    // R7 command write and pulse
    bus_write(3, 32'hABCD_EF3C, lat);
    chk("R7 pulse with ack", 32'(pulse_at_ack), 1);
    chk("R7 cmd value", 32'(cmd_o), 32'h3C);
    bus_read(3, rd, lat);
    chk("R7 cmd reads zero", rd, 0);

    // R6 RAM window
    bus_write(16, 32'h1111_0000, lat);
    chk("R6 ram write latency", lat, 2);
    bus_write(17, 32'h2222_0001, lat);
    bus_write(31, 32'h3333_0002, lat);
    bus_read(16, rd, lat);
    chk("R6 ram word 16", rd, 32'h1111_0000);
    chk("R6 ram read latency", lat, 1);
    bus_read(31, rd, lat);
    chk("R6 ram word 31", rd, 32'h3333_0002);
    bus_read(17, rd, lat);
    chk("R6 ram word 17", rd, 32'h2222_0001);

    // R5 unmapped
    bus_write(5, 32'hDEAD_BEEF, lat);
    chk("R5 unmapped write acked", lat, 1);
    bus_read(5, rd, lat);
    chk("R5 unmapped read zero", rd, 0);
    bus_read(40, rd, lat);
    chk("R5 high unmapped read zero", rd, 0);
    chk("R5 ctrl unchanged", ctrl_o, 32'h1234_5678);
    chk("R5 cmd unchanged", 32'(cmd_o), 32'h3C);

    // R1 half-enabled strobes never ack
    @(negedge clk); cyc = 1; stb = 0; we = 1; adr = '0; dat = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 cyc only no ack", 32'(ack_o), 0);
    cyc = 0; stb = 1;
    repeat (3) @(negedge clk);
    chk("R1 stb only no ack", 32'(ack_o), 0);
    chk("R1 ctrl unchanged", ctrl_o, 32'h1234_5678);
    stb = 0; we = 0;

    // R3/R7 held request: acks and pulses alternate, model judges each clock
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = 6'd3; dat = 32'h0000_0055;
    repeat (5) @(negedge clk);
    cyc = 0; stb = 0; we = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule